// File: doc/BRIEF.md
# Power and Serial Mode Control Register

This block is an 8-bit special-function register that the CPU can read and write at one address. It turns its mode bits into control signals for the rest of a small microcontroller. The first two signals are clock enables: one for the CPU core and one for the peripheral domain, which holds the serial, timer and interrupt logic. There are two low-power bits. The idle bit stops only the CPU clock. The power-down bit stops both clocks. Separate wake inputs clear each of these bits in hardware.

The register also has a baud-doubling bit and a frame-error select bit. The serial port uses the baud-doubling select only when it is in one of its non-zero modes. The frame-error select decides where bit 7 of the serial control register goes. Reads and writes of that bit reach either a frame-error flag or the normal serial mode bit. The block makes the two write strobes for that bit and drives the bit that is read back. Two more bits are general-purpose flags that software can read and write and that drive nothing. The clock gating cells, the CPU and the serial port are outside this block.

Top module: `pwr_ser_ctl`

## Requirements
- R1: After reset the register holds 0x00. The CPU and peripheral clock enables are both 1 and the baud-double output is 0.
- R2: A write (`sfr_wr`=1) at address 0x87 loads the register on the next clock edge from the write data ANDed with 0xCF. The field positions are: bit 7 baud double, bit 6 frame-error select, bit 3 flag 1, bit 2 flag 0, bit 1 power-down, bit 0 idle. The read data is combinational. It equals the register when the address is 0x87 and 0x00 at any other address.
- R3: Bits 5 and 4 always read 0 and ignore writes.
- R4: While the power-down bit (bit 1) is 1, both clock enables are 0, whatever the idle bit holds.
- R5: While idle (bit 0) is 1 and power-down is 0, the CPU clock enable is 0 and the peripheral clock enable stays 1.
- R6: The baud-double output is 1 exactly when bit 7 is 1 and the serial mode input is non-zero (modes 1, 2, 3).
- R7: A write at the serial control address 0x98 pulses the frame-error write strobe when bit 6 is 1 and the mode-bit write strobe when bit 6 is 0. It never pulses both. The read bit equals the frame-error flag input when bit 6 is 1 and the mode-bit input when bit 6 is 0. The bit written is write-data bit 7.
- R8: An interrupt wake pulse clears the idle bit on the next edge. It takes priority over a write in the same cycle.
- R9: An external wake pulse clears the power-down bit on the next edge. It takes priority over a write in the same cycle.
- R10: The two flag bits have no effect on the clock enables, the baud output or the serial strobes.
- R11: A write at any address other than 0x87 leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Register read data, 0 away from 0x87 |
| irq_wake | input | 1 | Enabled interrupt pending; clears idle |
| ext_wake | input | 1 | External wake request; clears power-down |
| ser_mode | input | 2 | Current serial port mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| baud_x2 | output | 1 | Baud-doubling select |
| scon_b7_fe_in | input | 1 | Frame-error flag from the serial port |
| scon_b7_mode_in | input | 1 | Serial mode bit from the serial port |
| scon_b7_rd | output | 1 | Serial control bit 7 as read |
| scon_b7_fe_we | output | 1 | Write strobe for the frame-error flag |
| scon_b7_mode_we | output | 1 | Write strobe for the serial mode bit |
| scon_b7_wbit | output | 1 | Value written to serial control bit 7 |

## Verification
The assertions check on every cycle that the wake inputs clear their bits on the next edge, that a write at the address lands in the following cycle, and that the reserved bits read as zero. They also check that the peripheral enable never drops while the CPU enable is high, that mode 0 never doubles the baud rate, and that the two serial write strobes are never active together. Other checks need scenarios that only the bench builds: a wake in the same cycle as a write that sets the bit, writes at other addresses, and flag-only settings that must leave every control output as it was.

// File: rtl/pwr_ser_pkg.sv
package pwr_ser_pkg;

  typedef struct packed {
    logic       dbl;
    logic       fe_sel;
    logic [1:0] rsvd;
    logic       flag1;
    logic       flag0;
    logic       pdn;
    logic       idle;
  } pctl_t;

  localparam logic [7:0] PCTL_WMASK = 8'hCF;
  localparam logic [7:0] PCTL_RST   = 8'h00;

  function automatic pctl_t pctl_write(input logic [7:0] wdata);
    return pctl_t'(wdata & PCTL_WMASK);
  endfunction

  function automatic logic cpu_enable(input logic pdn, input logic idle);
    return ~(pdn | idle);
  endfunction

  function automatic logic per_enable(input logic pdn);
    return ~pdn;
  endfunction

endpackage

// File: rtl/pwr_ser_regfile.sv
module pwr_ser_regfile
  import pwr_ser_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              irq_wake,
  input  logic              ext_wake,
  output pctl_t             pctl_q,
  output logic [7:0]        rdata
);

  logic  hit;
  logic  wr_hit;
  pctl_t pctl_d;

  always_comb begin
    hit    = (addr == REG_ADDR);
    wr_hit = wr && hit;
  end

  always_comb begin
    pctl_d = pctl_q;
    if (wr_hit) pctl_d = pctl_write(wdata);
    if (irq_wake) pctl_d.idle = 1'b0;
    if (ext_wake) pctl_d.pdn  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pctl_q <= pctl_t'(PCTL_RST);
    else        pctl_q <= pctl_d;
  end

  always_comb rdata = hit ? 8'(pctl_q) : 8'h00;

  AST_IRQ_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wake |=> !pctl_q.idle); // R8
  AST_EXT_CLEARS_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wake |=> !pctl_q.pdn); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !irq_wake && !ext_wake) |=> (8'(pctl_q) == ($past(wdata) & 8'hCF))); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !irq_wake && !ext_wake) |=> $stable(pctl_q)); // R11
  always_comb begin
    if (rst_n) AST_RSVD_ZERO: assert (rdata[5:4] == 2'b00); // R3
  end

endmodule

// File: rtl/pwr_ser_clk_ctl.sv
module pwr_ser_clk_ctl
  import pwr_ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pdn,
  input  logic idle,
  output logic cpu_en,
  output logic per_en
);

  always_comb begin
    cpu_en = cpu_enable(pdn, idle);
    per_en = per_enable(pdn);
  end

  AST_PER_OFF_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !per_en |-> !cpu_en); // R4

endmodule

// File: rtl/pwr_ser_baud_sel.sv
module pwr_ser_baud_sel #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbl,
  input  logic [MODE_W-1:0] mode,
  output logic              baud_x2
);

  localparam logic [MODE_W-1:0] MODE_ZERO = '0;

  always_comb baud_x2 = dbl && (mode != MODE_ZERO);

  AST_MODE0_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ZERO) |-> !baud_x2); // R6

endmodule

// File: rtl/pwr_ser_scon_mux.sv
module pwr_ser_scon_mux #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SCON_ADDR = 8'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              wbit_in,
  input  logic              fe_sel,
  input  logic              fe_in,
  input  logic              mode_in,
  output logic              fe_we,
  output logic              mode_we,
  output logic              wbit,
  output logic              rd_bit
);

  logic scon_wr;

  always_comb begin
    scon_wr = wr && (addr == SCON_ADDR);
    fe_we   = scon_wr && fe_sel;
    mode_we = scon_wr && !fe_sel;
    wbit    = wbit_in;
    rd_bit  = fe_sel ? fe_in : mode_in;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fe_we, mode_we})); // R7

endmodule

// File: rtl/pwr_ser_ctl.sv
module pwr_ser_ctl
  import pwr_ser_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MODE_W = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h87,
  parameter logic [ADDR_W-1:0] SCON_ADDR = 8'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              irq_wake,
  input  logic              ext_wake,
  input  logic [MODE_W-1:0] ser_mode,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              baud_x2,
  input  logic              scon_b7_fe_in,
  input  logic              scon_b7_mode_in,
  output logic              scon_b7_rd,
  output logic              scon_b7_fe_we,
  output logic              scon_b7_mode_we,
  output logic              scon_b7_wbit
);

  pctl_t pctl;

  pwr_ser_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wr(sfr_wr), .wdata(sfr_wdata),
    .irq_wake(irq_wake), .ext_wake(ext_wake), .pctl_q(pctl), .rdata(sfr_rdata)
  );

  pwr_ser_clk_ctl u_clk (
    .clk(clk), .rst_n(rst_n), .pdn(pctl.pdn), .idle(pctl.idle),
    .cpu_en(cpu_clk_en), .per_en(per_clk_en)
  );

  pwr_ser_baud_sel #(.MODE_W(MODE_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .dbl(pctl.dbl), .mode(ser_mode), .baud_x2(baud_x2)
  );

  pwr_ser_scon_mux #(.ADDR_W(ADDR_W), .SCON_ADDR(SCON_ADDR)) u_scon (
    .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wr(sfr_wr), .wbit_in(sfr_wdata[7]),
    .fe_sel(pctl.fe_sel), .fe_in(scon_b7_fe_in), .mode_in(scon_b7_mode_in),
    .fe_we(scon_b7_fe_we), .mode_we(scon_b7_mode_we), .wbit(scon_b7_wbit),
    .rd_bit(scon_b7_rd)
  );

  AST_PDN_STOPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_wake) == 1'b0 && sfr_rdata == 8'h00 && sfr_addr == REG_ADDR) |-> per_clk_en); // R4
  AST_IDLE_KEEPS_PER: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == REG_ADDR && sfr_rdata[1:0] == 2'b01) |-> (per_clk_en && !cpu_clk_en)); // R5

endmodule

// File: tb/tb_pwr_ser_ctl.sv
module tb_pwr_ser_ctl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sfr_addr;
  logic       sfr_wr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;
  logic       irq_wake, ext_wake;
  logic [1:0] ser_mode;
  logic       cpu_clk_en, per_clk_en, baud_x2;
  logic       fe_in, mode_in, b7_rd, fe_we, mode_we, b7_wbit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] model;

  always #10 clk = ~clk;

  pwr_ser_ctl dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .irq_wake(irq_wake), .ext_wake(ext_wake), .ser_mode(ser_mode),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .baud_x2(baud_x2),
    .scon_b7_fe_in(fe_in), .scon_b7_mode_in(mode_in), .scon_b7_rd(b7_rd),
    .scon_b7_fe_we(fe_we), .scon_b7_mode_we(mode_we), .scon_b7_wbit(b7_wbit)
  );

  function automatic logic [7:0] next_model(input logic [7:0] cur);
    logic [7:0] n;
    n = cur;
    if (sfr_wr && sfr_addr == 8'h87) n = {sfr_wdata[7:6], 2'b00, sfr_wdata[3:0]};
    if (irq_wake) n[0] = 1'b0;
    if (ext_wake) n[1] = 1'b0;
    return n;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_enables(input string req);
    check(req, {7'd0, cpu_clk_en}, {7'd0, !(model[1] || model[0])});
    check(req, {7'd0, per_clk_en}, {7'd0, !model[1]});
  endtask

  task automatic check_comb(input string req);
    check({req, "/R2 rdata"}, sfr_rdata, (sfr_addr == 8'h87) ? model : 8'h00);
    check("R6 baud", {7'd0, baud_x2}, {7'd0, model[7] && ser_mode != 2'd0});
    check("R7 fe_we", {7'd0, fe_we}, {7'd0, sfr_wr && sfr_addr == 8'h98 && model[6]});
    check("R7 mode_we", {7'd0, mode_we}, {7'd0, sfr_wr && sfr_addr == 8'h98 && !model[6]});
    check("R7 rd", {7'd0, b7_rd}, {7'd0, model[6] ? fe_in : mode_in});
    check("R7 wbit", {7'd0, b7_wbit}, {7'd0, sfr_wdata[7]});
  endtask

  task automatic idle_inputs();
    sfr_addr = 8'h00; sfr_wr = 1'b0; sfr_wdata = 8'h00;
    irq_wake = 1'b0; ext_wake = 1'b0;
  endtask

  task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                      input logic iw, input logic ew);
    @(negedge clk);
    sfr_addr = a; sfr_wr = w; sfr_wdata = d; irq_wake = iw; ext_wake = ew;
    #1;
    check_comb("step");
    model = next_model(model);
    @(negedge clk);
    idle_inputs();
    sfr_addr = 8'h87;
    #1;
    check("R2 readback", sfr_rdata, model);
    check_enables("R4/R5 enables");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; idle_inputs(); ser_mode = 2'd1; fe_in = 1'b1; mode_in = 1'b0;
    model = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    sfr_addr = 8'h87; #1;
    check("R1 reset value", sfr_rdata, 8'h00);
    check("R1 cpu_en", {7'd0, cpu_clk_en}, 8'd1);
    check("R1 per_en", {7'd0, per_clk_en}, 8'd1);
    check("R1 baud", {7'd0, baud_x2}, 8'd0);

    step(8'h87, 1'b1, 8'h30, 1'b0, 1'b0);
    check("R3 rsvd ignored", sfr_rdata, 8'h00);
    step(8'h87, 1'b1, 8'h0C, 1'b0, 1'b0);
    check("R10 flags cpu_en", {7'd0, cpu_clk_en}, 8'd1);
    check("R10 flags per_en", {7'd0, per_clk_en}, 8'd1);
    check("R10 flags baud", {7'd0, baud_x2}, 8'd0);
    step(8'h87, 1'b1, 8'h01, 1'b0, 1'b0);
    check("R5 idle cpu off", {7'd0, cpu_clk_en}, 8'd0);
    check("R5 idle per on", {7'd0, per_clk_en}, 8'd1);
    step(8'h87, 1'b1, 8'h03, 1'b1, 1'b0);
    check("R8 irq wins over write", sfr_rdata, 8'h02);
    check("R4 pdn both off", {6'd0, cpu_clk_en, per_clk_en}, 8'd0);
    step(8'h55, 1'b1, 8'hFF, 1'b0, 1'b0);
    check("R11 other addr", sfr_rdata, 8'h02);
    step(8'h87, 1'b1, 8'h83, 1'b0, 1'b1);
    check("R9 ext wins over write", sfr_rdata, 8'h81);
    step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    ser_mode = 2'd0; #1;
    check("R6 mode0 no double", {7'd0, baud_x2}, 8'd0);
    ser_mode = 2'd3; #1;
    check("R6 mode3 double", {7'd0, baud_x2}, 8'd1);
    step(8'h87, 1'b1, 8'h40, 1'b0, 1'b0);
    step(8'h98, 1'b1, 8'h80, 1'b0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      case ($urandom % 4)
        0, 1: a = 8'h87;
        2: a = 8'h98;
        default: a = 8'($urandom);
      endcase
      ser_mode = 2'($urandom);
      fe_in = 1'($urandom);
      mode_in = 1'($urandom);
      step(a, 1'($urandom), 8'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule